// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks one line reservation per requester so that a cache controller can decide the outcome of load-linked / store-conditional atomic pairs. The controller reports completed memory events on a single event port: a load-linked that finished, a store-conditional that was issued, a store-conditional that finished, and an ordinary write that finished. Each event carries a line address and a requester ID. A second port carries invalidations for a line address. An invalidation is either a loss of coherence permission or an eviction.

For every finished store-conditional, the block returns one result beat that says whether the store may commit. A store-conditional succeeds only when its own requester still holds a reservation on that exact line. Reservations are dropped by these events:
- a store-conditional that finishes on the reserved line, from any requester and whatever its outcome;
- a same-requester ordinary write to the reserved line;
- an eviction of the line;
- a loss of coherence permission, but only while a store-conditional to that line is in flight.

The data write, coherence messaging and request queuing are handled elsewhere.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no requester holds a reservation: `res_valid` is 0, and a store-conditional finished by any requester reports failure.
- R2: A load-linked finished by requester X on line L sets X's reservation on L. A following store-conditional finish by X on L reports `res_ok`=1.
- R3: A store-conditional finish reports `res_ok`=0 in each of these cases: the requester holds no reservation; it holds a reservation on a different line; or the line is reserved only by another requester.
- R4: Event kinds are encoded on `ev_kind` as 0 = load-linked finished, 1 = store-conditional issued, 2 = store-conditional finished, 3 = ordinary write finished. The result appears in the cycle after a kind-2 event, with `res_valid`=1. `res_valid` is 0 in the cycle after any other event kind or an idle cycle.
- R5: A store-conditional finish on line L clears every reservation on L, whether it succeeds or fails.
- R6: An ordinary write finished by requester X on line L clears X's reservation on L. The same write leaves other requesters' reservations and X's reservation on another line unchanged.
- R7: A coherence-loss invalidation (`inv_evict`=0) of line L clears all reservations on L only while some requester has an issued but unfinished store-conditional to L. Otherwise it has no effect.
- R8: An eviction invalidation (`inv_evict`=1) of line L clears every reservation on L and leaves reservations on other lines intact.
- R9: When a load-linked finish and an invalidation of either kind for the same line arrive in the same cycle, the requester is left with no reservation. An invalidation of a different line in that cycle does not stop the reservation being set.
- R10: Each requester holds at most one reservation. A new load-linked replaces that requester's earlier reservation.
- R11: A store-conditional outcome is decided from the reservations held before that cycle's invalidation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event kind (see R4) |
| ev_line | input | LINE_W | Line address of the event |
| ev_id | input | ID_W | Requester ID of the event |
| inv_valid | input | 1 | Invalidation present this cycle |
| inv_evict | input | 1 | 1 = eviction, 0 = coherence permission lost |
| inv_line | input | LINE_W | Line address being invalidated |
| res_valid | output | 1 | Store-conditional result beat |
| res_ok | output | 1 | 1 = store-conditional succeeded, 0 = failed |

## Verification
The hardest case to reach is a coherence loss that must clear a reservation. It only does so while a store-conditional to the same line has been issued but not yet finished, which takes three separate events in order. The bench issues a load-linked, then a store-conditional issue, then the coherence loss, and only then the finish. It runs the same sequence with the pending store aimed at a different line, and again with nothing pending, so that the gating is observed at `res_ok`. Same-cycle collisions between load-linked and invalidation, and between a store-conditional finish and an eviction, are driven by presenting both ports in one cycle.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NUM_REQ = 4,
  parameter int LINE_W  = 26,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [LINE_W-1:0] ev_line,
  input  logic [ID_W-1:0]   ev_id,
  input  logic              inv_valid,
  input  logic              inv_evict,
  input  logic [LINE_W-1:0] inv_line,
  output logic              res_valid,
  output logic              res_ok
);
  localparam logic [1:0] K_LL = 2'd0, K_SC_ISSUE = 2'd1, K_SC_DONE = 2'd2, K_WRITE = 2'd3;

  logic [NUM_REQ-1:0] rsv_v, pend_v, own_ok;
  logic [LINE_W-1:0]  rsv_line  [NUM_REQ];
  logic [LINE_W-1:0]  pend_line [NUM_REQ];
  logic               loss_armed;

  wire is_ll  = ev_valid && ev_kind == K_LL;
  wire is_sci = ev_valid && ev_kind == K_SC_ISSUE;
  wire is_scd = ev_valid && ev_kind == K_SC_DONE;
  wire is_wr  = ev_valid && ev_kind == K_WRITE;
  wire ll_hit_inv = inv_valid && inv_line == ev_line;

  always_comb begin
    loss_armed = 1'b0;
    for (int i = 0; i < NUM_REQ; i++)
      if (pend_v[i] && pend_line[i] == inv_line) loss_armed = 1'b1;
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    logic v, pv;
    logic [LINE_W-1:0] ln, pln;
    wire sel    = ev_id == ID_W'(g);
    wire on_ev  = v && ln == ev_line;
    wire on_inv = v && ln == inv_line;
    wire kill   = (inv_valid && on_inv && (inv_evict || loss_armed))
                || (is_scd && on_ev)
                || (is_wr && sel && on_ev);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v   <= 1'b0;
        pv  <= 1'b0;
        ln  <= '0;
        pln <= '0;
      end else begin
        if (is_ll && sel) begin
          v  <= !ll_hit_inv;
          ln <= ev_line;
        end else if (kill) begin
          v <= 1'b0;
        end
        if (is_sci && sel) begin
          pv  <= 1'b1;
          pln <= ev_line;
        end else if (is_scd && sel) begin
          pv <= 1'b0;
        end
      end
    end

    assign rsv_v[g]     = v;
    assign pend_v[g]    = pv;
    assign rsv_line[g]  = ln;
    assign pend_line[g] = pln;
    assign own_ok[g]    = sel && on_ev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= is_scd;
      res_ok    <= is_scd && |own_ok;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [1:0]        ev_kind,
  input logic [LINE_W-1:0] ev_line,
  input logic [ID_W-1:0]   ev_id,
  input logic              inv_valid,
  input logic              inv_evict,
  input logic [LINE_W-1:0] inv_line,
  input logic              res_valid,
  input logic              res_ok
);
  wire scd = ev_valid && ev_kind == 2'd2;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !res_valid);

  p_result_after_scd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scd |=> res_valid);

  p_no_spurious_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !scd |=> !res_valid);

  p_ok_only_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |-> res_valid);

  p_ll_then_sc_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scd && $past(rst_n) && $past(ev_valid && ev_kind == 2'd0 && !inv_valid)
     && $past(ev_id) == ev_id && $past(ev_line) == ev_line) |=> res_ok);

  p_back_to_back_sc_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scd && $past(scd) && $past(ev_line) == ev_line) |=> !res_ok);

  p_ll_lost_to_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scd && $past(ev_valid && ev_kind == 2'd0 && inv_valid && inv_line == ev_line)
     && $past(ev_id) == ev_id && $past(ev_line) == ev_line) |=> !res_ok);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) chk_i (.*);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
  localparam int NR = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = '0;
  logic [LW-1:0] ev_line = '0;
  logic [1:0] ev_id = '0;
  logic inv_valid = 1'b0;
  logic inv_evict = 1'b0;
  logic [LW-1:0] inv_line = '0;
  logic res_valid, res_ok;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_REQ(NR), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_line(ev_line), .ev_id(ev_id), .inv_valid(inv_valid),
    .inv_evict(inv_evict), .inv_line(inv_line),
    .res_valid(res_valid), .res_ok(res_ok));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit ev, input int k, input int id, input int ln,
                      input bit iv, input bit ie, input int il);
    ev_valid  = ev;
    ev_kind   = 2'(k);
    ev_id     = 2'(id);
    ev_line   = LW'(ln);
    inv_valid = iv;
    inv_evict = ie;
    inv_line  = LW'(il);
    @(negedge clk);
    ev_valid  = 1'b0;
    inv_valid = 1'b0;
  endtask

  task automatic ll(input int id, input int ln);          step(1, 0, id, ln, 0, 0, 0); endtask
  task automatic sci(input int id, input int ln);         step(1, 1, id, ln, 0, 0, 0); endtask
  task automatic wr(input int id, input int ln);          step(1, 3, id, ln, 0, 0, 0); endtask
  task automatic inv(input bit ie, input int ln);         step(0, 0, 0, 0, 1, ie, ln); endtask

  task automatic sc(input int id, input int ln, input int exp, input string tag);
    step(1, 2, id, ln, 0, 0, 0);
    check({tag, " valid"}, res_valid, 1);
    check(tag, res_ok, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NR; i++) sc(i, 0, 0, "R1 sc after reset");

    // R2 / R3 sweep over requester pairs and line pairs
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int x = 0; x < 2; x++)
          for (int y = 0; y < 2; y++) begin
            int la = x ? 5 : 1;
            int lb = y ? 5 : 1;
            ll(a, la);
            check("R4 no result after ll", res_valid, 0);
            sc(b, lb, (a == b && la == lb) ? 1 : 0, (a == b && la == lb) ? "R2" : "R3");
            inv(1, la);
            check("R4 no result after inv", res_valid, 0);
          end

    // R5
    ll(1, 3); sc(2, 3, 0, "R5 other sc fails"); sc(1, 3, 0, "R5 cleared by failed sc");
    ll(1, 3); sc(1, 3, 1, "R5 first ok");       sc(1, 3, 0, "R5 cleared by ok sc");
    ll(0, 4); ll(1, 4); sc(0, 4, 1, "R5 ok"); sc(1, 4, 0, "R5 other cleared");

    // R6
    ll(2, 7); wr(3, 7); check("R4 no result after write", res_valid, 0);
    sc(2, 7, 1, "R6 other write ignored");
    ll(2, 7); wr(2, 7); sc(2, 7, 0, "R6 own write clears");
    ll(2, 7); wr(2, 8); sc(2, 7, 1, "R6 other line write ignored");

    // R7
    ll(0, 4); inv(0, 4); sc(0, 4, 1, "R7 loss without pending");
    ll(0, 4); sci(0, 4); check("R4 no result after issue", res_valid, 0);
    inv(0, 4); sc(0, 4, 0, "R7 loss with pending");
    ll(1, 6); sci(0, 4); inv(0, 6); sc(1, 6, 1, "R7 pending other line");
    sc(0, 4, 0, "R7 pending finish");
    ll(1, 6); inv(0, 6); sc(1, 6, 1, "R7 pending cleared by finish");

    // R8
    ll(0, 9); ll(1, 9); ll(2, 10); inv(1, 9);
    sc(0, 9, 0, "R8 evict req0"); sc(1, 9, 0, "R8 evict req1"); sc(2, 10, 1, "R8 other line kept");

    // R9
    step(1, 0, 3, 11, 1, 1, 11); sc(3, 11, 0, "R9 ll vs evict");
    step(1, 0, 3, 11, 1, 0, 11); sc(3, 11, 0, "R9 ll vs loss");
    step(1, 0, 3, 11, 1, 1, 12); sc(3, 11, 1, "R9 different line");

    // R10
    ll(0, 1); ll(0, 2); sc(0, 1, 0, "R10 replaced"); sc(0, 2, 1, "R10 newest");

    // R11
    ll(2, 5);
    step(1, 2, 2, 5, 1, 1, 5);
    check("R11 valid", res_valid, 1);
    check("R11 decided before evict", res_ok, 1);
    sc(2, 5, 0, "R11 cleared afterwards");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule